// File: doc/BRIEF.md
# Collision Vector Pipeline Initiation Controller

This block sits in front of a static (fixed-schedule) multi-stage pipeline and decides, one clock at a time, whether a new job may enter without two jobs ever needing the same stage in the same slot. It tracks the stages that jobs already in flight will still occupy as a bit vector of blocked future slots. On every clock this vector moves one slot closer to the present. Each time a job is admitted, the vector of slots that the job's own schedule forbids is merged back into it.

The forbidden-latency vector is derived offline from the pipeline's reservation table. It is applied on an input port and captured while reset is held. It can be replaced later, but only while no job is in flight. A requester asks for admission with a request line. In greedy mode the controller instead admits a job at every slot that is free, which gives the shortest repeating latency cycle that the greedy policy can reach.

Top module: `cvInitCtrl`

## Requirements
- R1: While rstN is low, grant is 0, cvState is all zeros and empty is 1. The vector on icvIn during the last clock edge with rstN low becomes the held forbidden-latency vector.
- R2: Bit k of icvIn is 1 when starting a second job k cycles after a first one collides. Bit k of cvState is 1 when an admission k cycles after the present cycle is blocked, so bit 0 describes the present cycle. grant is never 1 while cvState bit 0 is 1.
- R3: In a cycle without grant, the next cvState is the present one moved one position toward bit 0, with 0 entering at bit W-1.
- R4: In a cycle with grant, the next cvState is (present cvState OR held vector) moved one position toward bit 0. Example with held vector 6'h25: a grant from the empty state gives 6'h12, and a grant in the next cycle then gives 6'h1B.
- R5: With greedyMode at 0, grant equals req AND NOT cvState bit 0, outside reset.
- R6: With greedyMode at 1, grant is 1 in every cycle where cvState bit 0 is 0, whatever req is. Starting from empty with held vector 6'h25, the gaps between grants repeat 1,3,3, an average of 7/3 cycles.
- R7: With held vector 6'h25, a request arriving 2 or 5 cycles after the previous grant is refused. A request arriving 1, 3 or 4 cycles after it is granted, and so is one arriving 6 or more cycles after it.
- R8: empty is 1 exactly when cvState is all zeros. Without requests, the controller stays empty for any number of cycles.
- R9: When icvLoad is 1 in a cycle where cvState is all zeros, icvIn becomes the held vector from the next cycle on, and a grant in that same cycle still merges the old vector. When icvLoad is 1 while cvState is not all zeros, it has no effect.
- R10: For a reservation table with stage marks {0,5}, {1,3} and {2,4}, no sequence of grants ever places two jobs in one stage in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset; also captures icvIn |
| req | input | 1 | Request to admit a job in this cycle |
| greedyMode | input | 1 | 1: admit at every free slot, req ignored |
| icvLoad | input | 1 | Replace the held vector, accepted only when empty |
| icvIn | input | W | Forbidden-latency vector, bit k = latency k |
| grant | output | 1 | A job is admitted in this cycle |
| cvState | output | W | Blocked future slots, bit 0 = present cycle |
| empty | output | 1 | No blocked slot remains |

## Verification
A behavioural model in the bench keeps a list of admission times, each with its vector, and predicts grant, cvState and empty every cycle. Single request pulses at distances 1 to 7 after an admission separate the latencies that are forbidden from those that are allowed. A free-running greedy run shows whether the controller settles into the 1,3,3 cycle, which tells greedy admission apart from fixed spacing. Vector loads issued while busy and while idle show whether the empty-only rule holds. A long pseudo-random request pattern is replayed against the reservation table to catch any stage that two jobs would use in the same slot.

// File: rtl/cvInitPkg.sv
package cvInitPkg;

  // Strobes from the admission control to the state datapath.
  typedef struct packed {
    logic issue;    // a job enters the pipeline this cycle
    logic loadIcv;  // replace the held forbidden-latency vector
  } cvStrobes_t;

endpackage

// File: rtl/cvCtrl.sv
module cvCtrl
  import cvInitPkg::*;
(
  input  logic       run,
  input  logic       req,
  input  logic       greedyMode,
  input  logic       icvLoad,
  input  logic       slotBusy,
  input  logic       stateEmpty,
  output cvStrobes_t strobe
);

  logic wantIssue;

  // Greedy mode takes every free slot; otherwise admission follows req.
  assign wantIssue = greedyMode | req;

  always_comb begin
    strobe         = '0;
    strobe.issue   = run & wantIssue & ~slotBusy;
    // A new vector is only taken while nothing is in flight.
    strobe.loadIcv = run & icvLoad & stateEmpty;
  end

endmodule

// File: rtl/cvDatapath.sv
module cvDatapath
  import cvInitPkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] icvIn,
  input  cvStrobes_t   strobe,
  output logic [W-1:0] cvState,
  output logic         slotBusy,
  output logic         stateEmpty
);

  localparam logic [W-1:0] ZERO_VEC = '0;

  logic [W-1:0] icvReg;
  logic [W-1:0] mergedVec;
  logic [W-1:0] nextState;

  // Slots claimed by a job admitted now join the ones already blocked.
  assign mergedVec = strobe.issue ? (cvState | icvReg) : cvState;
  // Advance one slot: position 0 (the present cycle) drops off.
  assign nextState = mergedVec >> 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cvState <= ZERO_VEC;
      icvReg  <= icvIn;
    end else begin
      cvState <= nextState;
      if (strobe.loadIcv) icvReg <= icvIn;
    end
  end

  assign slotBusy   = cvState[0];
  assign stateEmpty = (cvState == ZERO_VEC);

endmodule

// File: rtl/cvInitCtrl.sv
module cvInitCtrl
  import cvInitPkg::*;
#(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         req,
  input  logic         greedyMode,
  input  logic         icvLoad,
  input  logic [W-1:0] icvIn,
  output logic         grant,
  output logic [W-1:0] cvState,
  output logic         empty
);

  cvStrobes_t strobe;
  logic       slotBusy;
  logic       stateEmpty;

  cvCtrl u_ctrl (
    .run        (rstN),
    .req        (req),
    .greedyMode (greedyMode),
    .icvLoad    (icvLoad),
    .slotBusy   (slotBusy),
    .stateEmpty (stateEmpty),
    .strobe     (strobe)
  );

  cvDatapath #(.W(W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .icvIn      (icvIn),
    .strobe     (strobe),
    .cvState    (cvState),
    .slotBusy   (slotBusy),
    .stateEmpty (stateEmpty)
  );

  assign grant = strobe.issue;
  assign empty = stateEmpty;

endmodule

// File: rtl/cvInitCtrl_chk.sv
module cvInitCtrl_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rstN,
  input logic         req,
  input logic         greedyMode,
  input logic         grant,
  input logic [W-1:0] cvState,
  input logic         empty
);

  // R2: never admit into a blocked present slot
  p_blocked_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> !cvState[0]);

  // R3: without admission the state only advances
  p_plain_shift_r3: assert property (@(posedge clk) disable iff (!rstN)
    !grant |=> (cvState == ($past(cvState) >> 1)));

  // R5: outside greedy mode a grant needs a request
  p_needs_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !greedyMode) |-> req);

  // R6: greedy mode takes every free slot
  p_greedy_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (greedyMode && !cvState[0]) |-> grant);

  // R8: an idle empty controller stays empty
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !grant) |=> empty);

endmodule

bind cvInitCtrl cvInitCtrl_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .req        (req),
  .greedyMode (greedyMode),
  .grant      (grant),
  .cvState    (cvState),
  .empty      (empty)
);

// File: tb/cvInitCtrl_test.sv
module cvInitCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int HIST = 2048;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         req = 1'b0;
  logic         greedyMode = 1'b0;
  logic         icvLoad = 1'b0;
  logic [W-1:0] icvIn = '0;
  logic         grant;
  logic [W-1:0] cvState;
  logic         empty;

  cvInitCtrl #(.W(W)) uut (
    .clk(clk), .rstN(rstN), .req(req), .greedyMode(greedyMode),
    .icvLoad(icvLoad), .icvIn(icvIn), .grant(grant),
    .cvState(cvState), .empty(empty)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int t = 0;
  bit done = 0;

  // Behavioural model: list of admission times with the vector each one used.
  int           admitT[$];
  logic [W-1:0] admitV[$];
  logic [W-1:0] icvCur;
  logic [W-1:0] tableIcv;
  logic         gHist [HIST];
  logic         lastGrant;
  logic [W-1:0] lastState;
  logic         lastEmpty;

  // Reservation table: two marks per stage.
  int marks [3][2] = '{'{0, 5}, '{1, 3}, '{2, 4}};
  bit collOn = 0;
  int collList[$];

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, t);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  function automatic logic [W-1:0] modelState(input int now);
    logic [W-1:0] s = '0;
    for (int i = 0; i < admitT.size(); i++) begin
      for (int k = 0; k < W; k++) begin
        int d = now + k - admitT[i];
        if (d >= 1 && d <= W - 1 && admitV[i][d]) s[k] = 1'b1;
      end
    end
    return s;
  endfunction

  task automatic step(input logic r, input logic g, input logic l,
                      input logic [W-1:0] v);
    logic [W-1:0] expS;
    logic expG;
    @(negedge clk);
    req = r; greedyMode = g; icvLoad = l; icvIn = v;
    #1;
    expS = modelState(t);
    expG = !expS[0] && (g || r);
    check(grant == expG, "R5/R6", "grant", grant, expG);
    check(cvState == expS, "R3/R4", "cvState", cvState, expS);
    check(empty == (expS == '0), "R8", "empty", empty, (expS == '0));
    lastGrant = grant; lastState = cvState; lastEmpty = empty;
    if (t < HIST) gHist[t] = grant;
    if (collOn && grant) begin
      bit clash = 0;
      foreach (collList[i]) begin
        for (int s = 0; s < 3; s++)
          for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
              if (collList[i] + marks[s][a] == t + marks[s][b]) clash = 1;
      end
      check(!clash, "R10", "stage collision", clash, 0);
      collList.push_back(t);
      if (collList.size() > 8) void'(collList.pop_front());
    end
    if (expG) begin admitT.push_back(t); admitV.push_back(icvCur); end
    if (l && expS == '0) icvCur = v;
    while (admitT.size() > 0 && t - admitT[0] >= W) begin
      void'(admitT.pop_front()); void'(admitV.pop_front());
    end
    t++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tableIcv);
  endtask

  // Collect grant times recorded in [from, to).
  task automatic grantsIn(input int from, input int to, output int times[$]);
    times = {};
    for (int i = from; i < to; i++) if (gHist[i]) times.push_back(i);
  endtask

  initial begin
    int gt[$];
    int t0;
    int sum;
    int pattern[3] = '{1, 3, 3};

    // Forbidden latencies from the reservation table.
    tableIcv = '0;
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          if (marks[s][b] - marks[s][a] >= 0 && marks[s][b] - marks[s][a] < W)
            tableIcv[marks[s][b] - marks[s][a]] = 1'b1;
    check(tableIcv == 6'h25, "R2", "table vector", tableIcv, 6'h25);

    // R1: reset state
    icvIn = tableIcv; req = 1'b1; greedyMode = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      check(grant == 1'b0, "R1", "grant in reset", grant, 0);
      check(cvState == '0, "R1", "state in reset", cvState, 0);
      check(empty == 1'b1, "R1", "empty in reset", empty, 1);
    end
    req = 1'b0; greedyMode = 1'b0;
    rstN = 1'b1;
    icvCur = tableIcv;

    // R8: idle stays empty
    idle(20);
    check(lastEmpty == 1'b1, "R8", "empty after idle", lastEmpty, 1);

    // R4: merge example
    step(1'b1, 1'b0, 1'b0, tableIcv);
    check(lastGrant == 1'b1, "R5", "first request granted", lastGrant, 1);
    step(1'b1, 1'b0, 1'b0, tableIcv);
    check(lastState == 6'h12, "R4", "state after one grant", lastState, 6'h12);
    step(1'b0, 1'b0, 1'b0, tableIcv);
    check(lastState == 6'h1B, "R4", "state after two grants", lastState, 6'h1B);
    idle(8);

    // R7: probe each latency with a single pulse
    for (int lat = 1; lat <= 7; lat++) begin
      step(1'b1, 1'b0, 1'b0, tableIcv);
      if (lat > 1) idle(lat - 1);
      step(1'b1, 1'b0, 1'b0, tableIcv);
      check(lastGrant == (lat != 2 && lat != 5), "R7", $sformatf("latency %0d", lat),
            lastGrant, (lat != 2 && lat != 5));
      idle(8);
    end

    // R6: greedy cycle 1,3,3 with average 7/3
    t0 = t;
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, tableIcv);
    grantsIn(t0, t, gt);
    check(gt.size() >= 10, "R6", "greedy grant count", gt.size(), 10);
    sum = 0;
    for (int i = 1; i < gt.size() && i <= 9; i++) begin
      check(gt[i] - gt[i-1] == pattern[(i-1) % 3], "R6", "greedy gap",
            gt[i] - gt[i-1], pattern[(i-1) % 3]);
      sum += gt[i] - gt[i-1];
    end
    check(3 * sum == 7 * 9, "R6", "average latency x3 over 9 gaps", 3 * sum, 63);
    idle(8);

    // R9: load while busy is ignored
    step(1'b0, 1'b1, 1'b0, tableIcv);
    step(1'b0, 1'b1, 1'b0, tableIcv);
    check(lastEmpty == 1'b0, "R9", "busy before load", lastEmpty, 0);
    step(1'b0, 1'b1, 1'b1, 6'h03);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, tableIcv);
    idle(8);
    t0 = t;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0, tableIcv);
    grantsIn(t0, t, gt);
    check(gt.size() >= 2 && gt[1] - gt[0] == 1, "R9", "gap after ignored load",
          gt.size() >= 2 ? gt[1] - gt[0] : -1, 1);
    idle(8);

    // R9: load while empty takes effect
    step(1'b0, 1'b0, 1'b1, 6'h03);
    t0 = t;
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b0, tableIcv);
    grantsIn(t0, t, gt);
    check(gt.size() >= 2 && gt[1] - gt[0] == 2, "R9", "gap after accepted load",
          gt.size() >= 2 ? gt[1] - gt[0] : -1, 2);
    idle(8);
    step(1'b0, 1'b0, 1'b1, tableIcv);
    idle(2);

    // R10: pseudo-random requests against the reservation table
    collOn = 1;
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 300; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[3], 1'b0, 1'b0, tableIcv);
      end
    end
    collOn = 0;

    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    summary();
    $finish;
  end

endmodule